// File: doc/BRIEF.md
# Vertical Reference Window Generator

This block counts video lines and drives a vertical reference output that is high only during the active-picture lines of each field. A line strobe arrives once per video line. A field strobe arrives on the same cycle as a line strobe, together with a field identifier. With identifier 0 it starts a new frame. With identifier 1 it re-aligns the count to the first line of the second field. The block reports the current line number, the current field, and a wrap error when a frame runs past its nominal length without a new frame start.

Two inputs choose the window. `mode_50` selects 625-line (50 Hz) or 525-line (60 Hz) timing. `len_long` selects the longer window, which adds one line at each end of the short window. Both inputs are taken only when a frame starts, so no window ever mixes old and new settings. In 525-line timing the internal count is three lower than the conventional line numbering: internal line 19 is conventional line 22.

Top module: `vref_window_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `vref`=0, `line_no`=0, `field_o`=0 and `wrap_err`=0. The active settings return to 525-line timing with the short window.
- R2: Each `line_stb` pulse that does not come with `field_stb` raises `line_no` by one. The new value is visible in the cycle after the strobe.
- R3: A `line_stb` with `field_stb`=1 and `field_id`=0 sets `line_no` to 1, `field_o` to 0 and `wrap_err` to 0. On the same edge it loads `mode_50` and `len_long` as the active settings.
- R4: A `line_stb` with `field_stb`=1 and `field_id`=1 sets `field_o` to 1. It sets `line_no` to 263 in 525-line timing and to 313 in 625-line timing.
- R5: `field_o` is 0 on lines below the second-field boundary (263 in 525-line timing, 313 in 625-line timing) and 1 from that boundary to the end of the frame.
- R6: In 525-line timing with the short window, `vref` is 1 exactly on lines 19 to 258 and 282 to 521.
- R7: In 525-line timing with the long window, `vref` is 1 exactly on lines 18 to 259 and 281 to 522.
- R8: In 625-line timing with the short window, `vref` is 1 exactly on lines 24 to 309 and 337 to 622.
- R9: In 625-line timing with the long window, `vref` is 1 exactly on lines 23 to 310 and 336 to 623.
- R10: Changes on `mode_50` or `len_long` between frame starts have no effect on `vref`, `line_no` or `field_o` until the next frame start.
- R11: A line strobe on the last line of the frame (525 or 625) without a frame start wraps `line_no` to 1 and `field_o` to 0, and sets `wrap_err`. `wrap_err` stays set until the next frame start.
- R12: `vref`, `line_no`, `field_o` and `wrap_err` change only in the cycle after a `line_stb`. A `field_stb` without `line_stb` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_stb | input | 1 | One-cycle pulse per video line |
| field_stb | input | 1 | Field marker, qualified by `line_stb` |
| field_id | input | 1 | 0: frame start, 1: second-field start |
| mode_50 | input | 1 | 1: 625-line timing, 0: 525-line timing |
| len_long | input | 1 | 1: long window, 0: short window |
| vref | output | 1 | High during the active-line window |
| line_no | output | 10 | Current line number, 1 is the first line of the frame |
| field_o | output | 1 | 0: first field, 1: second field |
| wrap_err | output | 1 | Frame overran without a frame start |

## Verification
Most faults in this block appear at the ports within one line strobe. A wrong line count shifts both `vref` edges and the `field_o` change by the same number of lines. A settings register that is loaded at the wrong time moves the window edges part-way through a frame. The bench walks complete frames in all four timing and length combinations and compares every line against window limits taken from the requirements. Faults in the wrap and re-alignment paths stay hidden until a frame overruns or a second-field marker arrives, so those cases have their own directed scenarios.

// File: rtl/vref_pkg.sv
`timescale 1ns/1ps
// Package: shared line-number type and window constants for the
// vertical reference generator. Only the long-window limits are kept
// here; the short window is derived by trimming one line at each end.
package vref_pkg;
    localparam int LINE_W = 10;
    typedef logic [LINE_W-1:0] line_t;

    // Frame length and second-field boundary per timing.
    localparam line_t FRAME_525 = line_t'(525);
    localparam line_t FRAME_625 = line_t'(625);
    localparam line_t FLD2_525  = line_t'(263);
    localparam line_t FLD2_625  = line_t'(313);

    // Long-window limits, first field and second field.
    localparam line_t W525_F1_LO = line_t'(18);
    localparam line_t W525_F1_HI = line_t'(259);
    localparam line_t W525_F2_LO = line_t'(281);
    localparam line_t W525_F2_HI = line_t'(522);
    localparam line_t W625_F1_LO = line_t'(23);
    localparam line_t W625_F1_HI = line_t'(310);
    localparam line_t W625_F2_LO = line_t'(336);
    localparam line_t W625_F2_HI = line_t'(623);

    typedef struct packed {
        line_t lo;
        line_t hi;
    } win_t;
endpackage

// File: rtl/vref_cfg_latch.sv
`timescale 1ns/1ps
// Module: holds the active timing and length settings.
// Assumes frame_go is a one-cycle qualified frame-start event; the
// settings change only then, so one frame never mixes two settings.
module vref_cfg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_go,
    input  logic mode_50,
    input  logic len_long,
    output logic act_50,
    output logic act_long
);
    // Load the selected settings on frame start; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_50   <= 1'b0;
            act_long <= 1'b0;
        end else if (frame_go) begin
            act_50   <= mode_50;
            act_long <= len_long;
        end
    end
endmodule

// File: rtl/vref_line_counter.sv
`timescale 1ns/1ps
// Module: line and field counter with frame and second-field
// re-alignment and overrun detection.
// Assumes field_stb only matters on a cycle with line_stb; the frame
// length and field boundary follow the active timing setting.
module vref_line_counter
    import vref_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_stb,
    input  logic  field_stb,
    input  logic  field_id,
    input  logic  act_50,
    output line_t line_no,
    output logic  field_o,
    output logic  wrap_err
);
    line_t frame_len;
    line_t fld2_line;
    line_t cnt_nxt;
    logic  fld_nxt;
    logic  err_nxt;
    logic  go_frame;
    logic  go_field2;
    line_t cnt_inc;

    // Pick frame length and second-field boundary for the active timing.
    always_comb begin
        frame_len = act_50 ? FRAME_625 : FRAME_525;
        fld2_line = act_50 ? FLD2_625 : FLD2_525;
    end

    // Decode the strobe combination for this line.
    always_comb begin
        go_frame  = line_stb && field_stb && !field_id;
        go_field2 = line_stb && field_stb && field_id;
        cnt_inc   = line_no + line_t'(1);
    end

    // Choose the next line, field and error state.
    always_comb begin
        cnt_nxt = line_no;
        fld_nxt = field_o;
        err_nxt = wrap_err;
        if (go_frame) begin
            cnt_nxt = line_t'(1);
            fld_nxt = 1'b0;
            err_nxt = 1'b0;
        end else if (go_field2) begin
            cnt_nxt = fld2_line;
            fld_nxt = 1'b1;
        end else if (line_stb) begin
            if (line_no >= frame_len) begin
                cnt_nxt = line_t'(1);
                fld_nxt = 1'b0;
                err_nxt = 1'b1;
            end else begin
                cnt_nxt = cnt_inc;
                if (cnt_inc == fld2_line) begin
                    fld_nxt = 1'b1;
                end
            end
        end
    end

    // Register the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_no  <= '0;
            field_o  <= 1'b0;
            wrap_err <= 1'b0;
        end else begin
            line_no  <= cnt_nxt;
            field_o  <= fld_nxt;
            wrap_err <= err_nxt;
        end
    end
endmodule

// File: rtl/vref_window_lut.sv
`timescale 1ns/1ps
// Module: returns the active-line window for the current field.
// Purely combinational. The long window comes from the constant table
// in the package; the short window is one line shorter at each end.
module vref_window_lut
    import vref_pkg::*;
(
    input  logic act_50,
    input  logic act_long,
    input  logic field,
    output win_t win
);
    win_t  base;
    line_t trim;

    // Select the long-window limits for timing and field.
    always_comb begin
        unique case ({act_50, field})
            2'b00:   base = '{lo: W525_F1_LO, hi: W525_F1_HI};
            2'b01:   base = '{lo: W525_F2_LO, hi: W525_F2_HI};
            2'b10:   base = '{lo: W625_F1_LO, hi: W625_F1_HI};
            default: base = '{lo: W625_F2_LO, hi: W625_F2_HI};
        endcase
    end

    // Shrink by one line at each end for the short window.
    always_comb begin
        trim   = act_long ? '0 : line_t'(1);
        win.lo = base.lo + trim;
        win.hi = base.hi - trim;
    end
endmodule

// File: rtl/vref_window_gen.sv
`timescale 1ns/1ps
// Module: top of the vertical reference generator. It ties the settings
// latch, the line counter and the window lookup together. vref is
// decoded from registered state only, so it moves only after a line
// strobe. Assumes line_stb is a single-cycle pulse.
module vref_window_gen (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       line_stb,
    input  logic                       field_stb,
    input  logic                       field_id,
    input  logic                       mode_50,
    input  logic                       len_long,
    output logic                       vref,
    output logic [vref_pkg::LINE_W-1:0] line_no,
    output logic                       field_o,
    output logic                       wrap_err
);
    import vref_pkg::*;

    logic act_50;
    logic act_long;
    logic frame_go;
    win_t win;

    // Qualified frame-start event for the settings latch.
    always_comb frame_go = line_stb && field_stb && !field_id;

    vref_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_go (frame_go),
        .mode_50  (mode_50),
        .len_long (len_long),
        .act_50   (act_50),
        .act_long (act_long)
    );

    vref_line_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_stb  (line_stb),
        .field_stb (field_stb),
        .field_id  (field_id),
        .act_50    (act_50),
        .line_no   (line_no),
        .field_o   (field_o),
        .wrap_err  (wrap_err)
    );

    vref_window_lut u_lut (
        .act_50   (act_50),
        .act_long (act_long),
        .field    (field_o),
        .win      (win)
    );

    // Window compare on the registered line number.
    always_comb vref = (line_no >= win.lo) && (line_no <= win.hi);
endmodule

// File: rtl/vref_window_gen_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for vref_window_gen, attached by bind.
module vref_window_gen_chk
    import vref_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  line_stb,
    input logic  field_stb,
    input logic  field_id,
    input logic  vref,
    input line_t line_no,
    input logic  field_o,
    input logic  wrap_err,
    input logic  act_50,
    input logic  act_long
);
    // R1: reset clears every output
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (line_no == '0 && !vref && !field_o && !wrap_err));

    // R12: no output change without a line strobe
    p_hold_between_lines_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> ($stable(line_no) && $stable(vref) && $stable(field_o) && $stable(wrap_err)));

    // R3: frame start restarts the count
    p_frame_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && field_stb && !field_id) |=> (line_no == line_t'(1) && !field_o && !wrap_err && !vref));

    // R4: second-field marker re-aligns the count
    p_field2_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && field_stb && field_id) |=> (field_o && line_no == (act_50 ? FLD2_625 : FLD2_525)));

    // R5: second field only at or after the boundary
    p_field_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        field_o |-> (line_no >= FLD2_525));

    // R6: window never reaches outside the widest limits
    p_vref_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vref |-> (line_no >= W525_F1_LO && line_no <= W625_F2_HI));

    // R10: settings move only on frame start
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_stb && field_stb && !field_id) |=> ($stable(act_50) && $stable(act_long)));

    // R11: overrun wraps and flags
    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !field_stb && line_no >= (act_50 ? FRAME_625 : FRAME_525)) |=> (wrap_err && line_no == line_t'(1)));

    // R11: flag holds until frame start
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_err && !(line_stb && field_stb && !field_id)) |=> wrap_err);
endmodule

bind vref_window_gen vref_window_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_stb  (line_stb),
    .field_stb (field_stb),
    .field_id  (field_id),
    .vref      (vref),
    .line_no   (line_no),
    .field_o   (field_o),
    .wrap_err  (wrap_err),
    .act_50    (act_50),
    .act_long  (act_long)
);

// File: tb/vref_window_gen_tb.sv
`timescale 1ns/1ps
module vref_window_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       field_stb = 1'b0;
    logic       field_id = 1'b0;
    logic       mode_50 = 1'b0;
    logic       len_long = 1'b0;
    logic       vref;
    logic [9:0] line_no;
    logic       field_o;
    logic       wrap_err;

    int  checks = 0;
    int  misses = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    vref_window_gen u_dut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
        .field_id(field_id), .mode_50(mode_50), .len_long(len_long),
        .vref(vref), .line_no(line_no), .field_o(field_o), .wrap_err(wrap_err)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    // Expected window, written from the requirement tables.
    function automatic int exp_vref(input logic m50, input logic lng, input int n);
        int a1, b1, a2, b2;
        if (!m50) begin
            a1 = lng ? 18 : 19;  b1 = lng ? 259 : 258;
            a2 = lng ? 281 : 282; b2 = lng ? 522 : 521;
        end else begin
            a1 = lng ? 23 : 24;  b1 = lng ? 310 : 309;
            a2 = lng ? 336 : 337; b2 = lng ? 623 : 622;
        end
        return ((n >= a1 && n <= b1) || (n >= a2 && n <= b2)) ? 1 : 0;
    endfunction

    function automatic int exp_field(input logic m50, input int n);
        return (n >= (m50 ? 313 : 263)) ? 1 : 0;
    endfunction

    // One line strobe; outputs are settled at the closing negedge.
    task automatic step(input logic fs, input logic fid);
        @(negedge clk);
        line_stb = 1'b1; field_stb = fs; field_id = fid;
        @(negedge clk);
        line_stb = 1'b0; field_stb = 1'b0; field_id = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 line_no", int'(line_no), 0);
        chk("R1 vref", int'(vref), 0);
        chk("R1 field_o", int'(field_o), 0);
        chk("R1 wrap_err", int'(wrap_err), 0);
    endtask

    // Walk a full frame and compare every line.
    task automatic t_frame(input logic m50, input logic lng, input string rq);
        int flen;
        flen = m50 ? 625 : 525;
        mode_50 = m50; len_long = lng;
        step(1'b1, 1'b0);
        chk("R3 line_no", int'(line_no), 1);
        for (int n = 2; n <= flen; n++) begin
            step(1'b0, 1'b0);
            chk("R2 line_no", int'(line_no), n);
            chk("R5 field_o", int'(field_o), exp_field(m50, n));
            chk(rq, int'(vref), exp_vref(m50, lng, n));
        end
    endtask

    task automatic t_idle();
        int ln;
        int vr;
        ln = int'(line_no);
        vr = int'(vref);
        repeat (5) @(negedge clk);
        chk("R12 idle line_no", int'(line_no), ln);
        @(negedge clk);
        field_stb = 1'b1; field_id = 1'b0;
        @(negedge clk);
        field_id = 1'b1;
        @(negedge clk);
        field_stb = 1'b0; field_id = 1'b0;
        @(negedge clk);
        chk("R12 lone field_stb line_no", int'(line_no), ln);
        chk("R12 lone field_stb vref", int'(vref), vr);
    endtask

    task automatic t_field_sync();
        mode_50 = 1'b0; len_long = 1'b0;
        step(1'b1, 1'b0);
        repeat (4) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        chk("R4 525 line_no", int'(line_no), 263);
        chk("R4 525 field_o", int'(field_o), 1);
        step(1'b0, 1'b0);
        chk("R4 525 next line", int'(line_no), 264);
        mode_50 = 1'b1;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R4 625 line_no", int'(line_no), 313);
        chk("R4 625 field_o", int'(field_o), 1);
    endtask

    task automatic t_mid_change();
        mode_50 = 1'b0; len_long = 1'b0;
        step(1'b1, 1'b0);
        mode_50 = 1'b1; len_long = 1'b1;
        for (int n = 2; n <= 300; n++) begin
            step(1'b0, 1'b0);
            if (n == 18 || n == 19 || n == 258 || n == 259)
                chk("R10 vref keeps old window", int'(vref), exp_vref(1'b0, 1'b0, n));
            if (n == 263)
                chk("R10 field keeps old boundary", int'(field_o), 1);
        end
        step(1'b1, 1'b0);
        for (int n = 2; n <= 24; n++) begin
            step(1'b0, 1'b0);
            if (n == 22 || n == 23)
                chk("R10 new window after frame start", int'(vref), exp_vref(1'b1, 1'b1, n));
        end
    endtask

    task automatic t_wrap();
        mode_50 = 1'b0; len_long = 1'b0;
        step(1'b1, 1'b0);
        for (int n = 2; n <= 525; n++) step(1'b0, 1'b0);
        chk("R11 at last line", int'(line_no), 525);
        chk("R11 no flag yet", int'(wrap_err), 0);
        step(1'b0, 1'b0);
        chk("R11 wrapped line_no", int'(line_no), 1);
        chk("R11 wrapped field_o", int'(field_o), 0);
        chk("R11 flag set", int'(wrap_err), 1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R11 flag held", int'(wrap_err), 1);
        chk("R11 count runs on", int'(line_no), 3);
        step(1'b1, 1'b0);
        chk("R11 flag cleared by frame start", int'(wrap_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_frame(1'b0, 1'b0, "R6 vref");
        t_idle();
        t_frame(1'b0, 1'b1, "R7 vref");
        t_frame(1'b1, 1'b0, "R8 vref");
        t_frame(1'b1, 1'b1, "R9 vref");
        t_field_sync();
        t_mid_change();
        t_wrap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            misses++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
            $finish;
        end
    end
endmodule